// File: doc/BRIEF.md
# Per-Lane Idle Pattern Generator

This block supplies the filler stream that a multi-lane serial transmitter sends while it has no packet or ordered set to put on the wire. Every lane owns an 11-stage linear feedback shift register. Each lane starts from its own seed, so the lanes sit at different points of the same pseudo-random sequence. On every symbol time in which the transmit multiplexer's control asserts the enable, each configured lane delivers one data byte. The K (control) indication stays low, because idle filler is always data. A later stage does the 8b/10b encoding.

A small run controller counts the consecutive enabled symbol times. It raises a flag once the minimum idle run has gone out on every lane, and the training logic waits for that flag before it declares the link up. The controller has three states. ST_OFF is idle with the enable low. ST_FILL means the run is in progress and the count is below the minimum. ST_MET means the minimum has been reached. The transitions are:

- BEGIN: ST_OFF to ST_FILL, when the enable rises.
- REACH: ST_FILL to ST_MET, when the count hits the minimum.
- STOP: ST_FILL or ST_MET to ST_OFF, whenever the enable is low.

Seeds are sampled on BEGIN.

Top module: `idle_pattern_gen`

## Requirements
- R1: Each lane register has 11 stages, held as state bits 0..10 for stages 1..11. One step shifts every stage toward the higher index, drops stage 11, and puts the XOR of stage 9 and stage 11 (bits 8 and 10) into stage 1 (bit 0). Before each step, stage 11 is the output bit.
- R2: On each clock edge that samples the enable high, every active lane advances 8 steps and its `idle_sym` byte at that edge holds the 8 output bits, with the first bit in byte bit 7. With a seed of 11'h400 the first two bytes are 8'h80 and 8'h10.
- R3: Lane i is active when i < `lane_cnt`, and a count of NUM_LANES or more makes every lane active. An inactive lane outputs 8'h00 and keeps its register unchanged. If it later becomes active, it resumes from the state it kept.
- R4: On the first enabled edge after the enable was low, or after reset, every lane loads its slice of `seed_flat` and then steps from it. A slice of all zeros is replaced by 11'h5A5, so the register never holds zero.
- R5: `min_run_done` rises at the edge that delivers the 16th consecutive idle byte. It stays high for as long as the enable stays high.
- R6: At the first edge that samples the enable low, all lane bytes become 8'h00, `min_run_done` clears and the run count restarts. The next enable reloads the seeds.
- R7: Every bit of `idle_is_k` is 0 at all times.
- R8: While `rst_n` is low, all lane bytes are 8'h00 and `min_run_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idle_en | input | 1 | High in each symbol time that idle filler is wanted |
| lane_cnt | input | $clog2(NUM_LANES+1) | Number of configured lanes |
| seed_flat | input | NUM_LANES*11 | Per-lane start states, lane i in bits [11i+10:11i] |
| idle_sym | output | NUM_LANES*8 | Per-lane idle byte, lane i in bits [8i+7:8i] |
| idle_is_k | output | NUM_LANES | Control-character flag per lane, always 0 |
| min_run_done | output | 1 | Minimum idle run has been sent |

## Verification
The bench goes after the boundaries of the run count. A design that is off by one in the count would raise the flag at the 15th or the 17th byte, or would keep it high across a dropped enable. It checks bit order against hand-worked bytes from a known seed, where a design that reversed the byte or used the wrong feedback taps would produce other values. An all-zero seed is applied: without the substitute seed that lane would lock up at 00 for good. The bench also shrinks and then regrows the lane count in the middle of a run, which shows whether a design lets inactive lanes drift or leaves their outputs non-zero. Finally, it re-enables after a gap to confirm that each lane goes back to its seed instead of continuing the old sequence.

// File: rtl/idle_pkg.sv
package idle_pkg;
    parameter int LFSR_W = 11;
    parameter int SYM_W  = 8;
    parameter int TAP_A  = 9;
    parameter int TAP_B  = 11;

    typedef struct packed {
        logic [LFSR_W-1:0] nxt;
        logic [SYM_W-1:0]  sym;
    } step_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_FILL = 2'd1,
        ST_MET  = 2'd2
    } run_state_t;

    // Advance the register one symbol worth of steps, first bit into the MSB.
    function automatic step_t idle_step_sym(input logic [LFSR_W-1:0] start);
        step_t             r;
        logic [LFSR_W-1:0] s;
        s = start;
        r.sym = '0;
        for (int i = 0; i < SYM_W; i++) begin
            r.sym[SYM_W-1-i] = s[LFSR_W-1];
            s = {s[LFSR_W-2:0], s[TAP_A-1] ^ s[TAP_B-1]};
        end
        r.nxt = s;
        return r;
    endfunction
endpackage

// File: rtl/idle_lane.sv
module idle_lane
    import idle_pkg::*;
#(
    parameter logic [LFSR_W-1:0] FALLBACK_SEED = 11'h5A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              lane_on_i,
    input  logic [LFSR_W-1:0] seed_i,
    output logic [SYM_W-1:0]  sym_o
);
    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] seed_fix;
    logic [LFSR_W-1:0] src;
    logic [SYM_W-1:0]  sym_q;
    step_t             res;

    always_comb begin
        seed_fix = (seed_i == '0) ? FALLBACK_SEED : seed_i;
        src      = load_i ? seed_fix : lfsr_q;
        res      = idle_step_sym(src);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= FALLBACK_SEED;
            sym_q  <= '0;
        end else if (load_i || step_i) begin
            if (lane_on_i) begin
                lfsr_q <= res.nxt;
                sym_q  <= res.sym;
            end else begin
                lfsr_q <= load_i ? seed_fix : lfsr_q;
                sym_q  <= '0;
            end
        end else begin
            sym_q <= '0;
        end
    end

    assign sym_o = sym_q;

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R4
    AST_OFF_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_on_i |=> (sym_o == '0)); // R3
    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !(step_i && lane_on_i)) |=> $stable(lfsr_q)); // R3
endmodule

// File: rtl/idle_run_ctrl.sv
module idle_run_ctrl
    import idle_pkg::*;
#(
    parameter int MIN_RUN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic load_o,
    output logic step_o,
    output logic done_o
);
    localparam int CW = $clog2(MIN_RUN + 1);

    run_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          done_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_OFF: begin
                if (en_i) begin
                    cnt_d = CW'(1);
                    st_d  = (MIN_RUN <= 1) ? ST_MET : ST_FILL;
                end
            end
            ST_FILL: begin
                if (!en_i) begin
                    cnt_d = '0;
                    st_d  = ST_OFF;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q + 1'b1 == CW'(MIN_RUN)) st_d = ST_MET;
                end
            end
            ST_MET: begin
                if (!en_i) begin
                    cnt_d = '0;
                    st_d  = ST_OFF;
                end
            end
            default: begin
                cnt_d = '0;
                st_d  = ST_OFF;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (st_d == ST_MET);
    end

    assign load_o = en_i && (st_q == ST_OFF);
    assign step_o = en_i && (st_q != ST_OFF);
    assign done_o = done_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MIN_RUN)); // R5
    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !done_o); // R6
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (cnt_q == CW'(MIN_RUN))); // R5
endmodule

// File: rtl/idle_pattern_gen.sv
module idle_pattern_gen
    import idle_pkg::*;
#(
    parameter int                NUM_LANES     = 4,
    parameter int                MIN_RUN       = 16,
    parameter logic [LFSR_W-1:0] FALLBACK_SEED = 11'h5A5,
    localparam int               LCW           = $clog2(NUM_LANES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        idle_en,
    input  logic [LCW-1:0]              lane_cnt,
    input  logic [NUM_LANES*LFSR_W-1:0] seed_flat,
    output logic [NUM_LANES*SYM_W-1:0]  idle_sym,
    output logic [NUM_LANES-1:0]        idle_is_k,
    output logic                        min_run_done
);
    logic                 load;
    logic                 step;
    logic [NUM_LANES-1:0] lane_on;

    idle_run_ctrl #(.MIN_RUN(MIN_RUN)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (idle_en),
        .load_o (load),
        .step_o (step),
        .done_o (min_run_done)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane_on[g] = (int'(lane_cnt) > g);

        idle_lane #(.FALLBACK_SEED(FALLBACK_SEED)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load),
            .step_i    (step),
            .lane_on_i (lane_on[g]),
            .seed_i    (seed_flat[g*LFSR_W +: LFSR_W]),
            .sym_o     (idle_sym[g*SYM_W +: SYM_W])
        );
    end

    // Idle filler is always data.
    assign idle_is_k = '0;
endmodule

// File: tb/tb_idle_pattern_gen.sv
module tb_idle_pattern_gen;
    localparam int NL  = 4;
    localparam int MIN = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            idle_en;
    logic [2:0]      lane_cnt;
    logic [NL*11-1:0] seed_flat;
    logic [NL*8-1:0]  idle_sym;
    logic [NL-1:0]    idle_is_k;
    logic             min_run_done;

    int n_chk  = 0;
    int n_fail = 0;

    logic [10:0] m_st [NL];
    bit          m_was_en;
    int          m_cnt;
    logic [7:0]  exp_sym [NL];
    bit          exp_done;

    always #10 clk = ~clk;

    idle_pattern_gen dut (
        .clk(clk), .rst_n(rst_n), .idle_en(idle_en), .lane_cnt(lane_cnt),
        .seed_flat(seed_flat), .idle_sym(idle_sym), .idle_is_k(idle_is_k),
        .min_run_done(min_run_done)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Stage-indexed model of one symbol time (stages 1..11).
    function automatic logic [18:0] model_sym(input logic [10:0] s);
        bit st [1:12];
        bit o, fb;
        logic [7:0]  b;
        logic [10:0] n;
        for (int k = 1; k <= 11; k++) st[k] = s[k-1];
        b = '0;
        for (int i = 0; i < 8; i++) begin
            o  = st[11];
            fb = st[9] ^ st[11];
            for (int k = 11; k >= 2; k--) st[k] = st[k-1];
            st[1] = fb;
            b = {b[6:0], o};
        end
        for (int k = 1; k <= 11; k++) n[k-1] = st[k];
        return {n, b};
    endfunction

    function automatic logic [10:0] fixed_seed(input int l);
        logic [10:0] v;
        v = seed_flat[l*11 +: 11];
        return (v == 11'd0) ? 11'h5A5 : v;
    endfunction

    // Drive one symbol time, update the model, sample after the edge.
    task automatic tick(input logic en, input string req);
        logic [18:0] r;
        idle_en = en;
        if (en) begin
            if (!m_was_en) for (int l = 0; l < NL; l++) m_st[l] = fixed_seed(l);
            for (int l = 0; l < NL; l++) begin
                if (l < int'(lane_cnt)) begin
                    r = model_sym(m_st[l]);
                    m_st[l] = r[18:8];
                    exp_sym[l] = r[7:0];
                end else exp_sym[l] = 8'h00;
            end
            if (m_cnt < MIN) m_cnt++;
        end else begin
            for (int l = 0; l < NL; l++) exp_sym[l] = 8'h00;
            m_cnt = 0;
        end
        exp_done = (m_cnt >= MIN);
        m_was_en = en;
        @(posedge clk); #1;
        for (int l = 0; l < NL; l++)
            chk(req, $sformatf("lane%0d byte", l), 32'(idle_sym[l*8 +: 8]), 32'(exp_sym[l]));
        chk("R5", "run flag", 32'(min_run_done), 32'(exp_done));
        chk("R7", "K flags", 32'(idle_is_k), 32'd0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0; idle_en = 1'b0; lane_cnt = 3'd4;
        seed_flat = {11'h123, 11'h2A7, 11'h051, 11'h400};
        m_was_en = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R8", "bytes in reset", 32'(idle_sym), 32'd0);
        chk("R8", "flag in reset", 32'(min_run_done), 32'd0);
        chk("R7", "K in reset", 32'(idle_is_k), 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic test_known_seed();
        tick(1'b1, "R2");
        chk("R1", "seed 400 byte0", 32'(idle_sym[7:0]), 32'h80);
        tick(1'b1, "R2");
        chk("R1", "seed 400 byte1", 32'(idle_sym[7:0]), 32'h10);
    endtask

    task automatic test_min_run();
        for (int i = 2; i < MIN - 1; i++) tick(1'b1, "R2");
        chk("R5", "flag low at 15", 32'(min_run_done), 32'd0);
        tick(1'b1, "R2");
        chk("R5", "flag high at 16", 32'(min_run_done), 32'd1);
        repeat (4) tick(1'b1, "R2");
        chk("R5", "flag held", 32'(min_run_done), 32'd1);
    endtask

    task automatic test_drop_restart();
        logic [7:0] first;
        tick(1'b0, "R6");
        chk("R6", "bytes zero after drop", 32'(idle_sym), 32'd0);
        chk("R6", "flag cleared", 32'(min_run_done), 32'd0);
        tick(1'b1, "R6");
        first = idle_sym[15:8];
        chk("R4", "lane1 reload", 32'(first), 32'(model_sym(11'h051) & 19'hFF));
        chk("R6", "flag restarted", 32'(min_run_done), 32'd0);
        tick(1'b0, "R6");
    endtask

    task automatic test_zero_seed();
        seed_flat[11 +: 11] = 11'd0;
        tick(1'b1, "R4");
        chk("R4", "zero seed lane1", 32'(idle_sym[15:8]), 32'(model_sym(11'h5A5) & 19'hFF));
        repeat (5) tick(1'b1, "R4");
        tick(1'b0, "R6");
    endtask

    task automatic test_lane_count();
        lane_cnt = 3'd2;
        repeat (4) tick(1'b1, "R3");
        chk("R3", "lanes 2,3 quiet", 32'(idle_sym[31:16]), 32'd0);
        lane_cnt = 3'd4;
        tick(1'b1, "R3");
        chk("R3", "lane2 resumes at seed", 32'(idle_sym[23:16]),
            32'(model_sym(11'h2A7) & 19'hFF));
        lane_cnt = 3'd7;
        repeat (3) tick(1'b1, "R3");
        lane_cnt = 3'd0;
        tick(1'b1, "R3");
        chk("R3", "no lanes", 32'(idle_sym), 32'd0);
        lane_cnt = 3'd1;
        repeat (MIN) tick(1'b1, "R5");
        tick(1'b0, "R6");
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        test_reset();
        test_known_seed();
        test_min_run();
        test_drop_restart();
        test_zero_seed();
        test_lane_count();
        summary();
        $finish;
    end
endmodule